// File: doc/BRIEF.md
# Non-uniform sector flash program and erase sequencer

This block sits between a control path and a flash array whose eight sectors differ in size. The map starts at byte 0. Sectors 0 to 3 hold 16 KiB each, sector 4 holds 64 KiB at 64 KiB, and sectors 5, 6 and 7 hold 128 KiB each at 128 KiB, 256 KiB and 384 KiB. The control path loads a set of control fields: program enable, program width, sector-erase enable and sector number. It can then pulse a start input, or write 32-bit words at array byte addresses. The block turns each accepted request into a one-cycle strobe toward the array. It then holds a busy flag for a fixed number of cycles that stands in for the array's own handshake.

The block also checks an erase byte range against the sector map. The range is accepted only when both ends fall on sector edges, and the block then reports the first and last sector it covers. Requests that break a rule leave the array untouched and raise a sticky error bit. The rules cover a busy array, a protected sector, a bad program width, a sector number out of range and a misaligned range. Software clears each error bit by writing a one to it.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy is 0, all five error bits are 0 and both array strobes are 0.
- R2: A range request with offset O and size S is answered one cycle later with rng_done=1. rng_ok is 1 only when O equals the base of some sector i and O+S equals the end of some sector j with j ≥ i. In that case rng_first=i and rng_last=j.
- R3: A range request that fails the R2 rule sets err[4], the parameter error, in the same cycle as rng_done, with rng_ok=0.
- R4: The control fields are loaded by a ctrl_we cycle, and a later ctrl_start pulse acts on them. If the sector-erase field is 1, the array is idle, the sector number is at most 7 and the sector is unprotected, then arr_erase_stb pulses for one cycle with arr_sector equal to the sector. Busy then stays high for ERASE_UNIT_LAT × (sector size / 16 KiB) cycles.
- R5: With program enable 1 and program width code 2'b10 (32-bit), a word write to an idle array pulses arr_prog_stb for one cycle, with the address on arr_addr and the word on arr_data. Busy then stays high for PROG_LAT cycles.
- R6: With program enable 1 and any program width code other than 2'b10, a word write sets err[1] and starts nothing. With program enable 0, a word write has no effect at all.
- R7: A start or word write that arrives while busy is high sets err[3]. It emits no strobe and does not extend busy.
- R8: A word write or erase aimed at a sector whose wp_mask bit is 1 sets err[2] and emits no strobe.
- R9: A start with a sector number above 7 sets err[0] and starts no erase.
- R10: A clr_we cycle clears the error bits that are 1 in clr_mask. If an error is raised in the same cycle that clears its bit, the bit stays set. Error bits never drop otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Load the control fields below |
| ctrl_pg | input | 1 | Program enable field |
| ctrl_psize | input | 2 | Program width code (2'b10 = 32-bit) |
| ctrl_ser | input | 1 | Sector-erase enable field |
| ctrl_snb | input | 4 | Sector number field |
| ctrl_start | input | 1 | Launch an erase using the stored fields |
| word_we | input | 1 | Word write to the array |
| word_addr | input | 19 | Byte address of the word |
| word_data | input | 32 | Word to program |
| wp_mask | input | 8 | Per-sector write protection |
| rng_req | input | 1 | Range check request |
| rng_off | input | 20 | Range start offset in bytes |
| rng_size | input | 20 | Range size in bytes |
| clr_we | input | 1 | Error clear write |
| clr_mask | input | 5 | Error bits to clear (write one) |
| busy | output | 1 | Array operation in progress |
| err | output | 5 | Sticky errors: [0] op fail, [1] width, [2] protect, [3] sequence, [4] parameter |
| rng_done | output | 1 | Range result valid |
| rng_ok | output | 1 | Range lies on sector edges |
| rng_first | output | 3 | First sector of the range |
| rng_last | output | 3 | Last sector of the range |
| arr_prog_stb | output | 1 | One-cycle word program strobe |
| arr_erase_stb | output | 1 | One-cycle sector erase strobe |
| arr_addr | output | 19 | Program address toward the array |
| arr_data | output | 32 | Program word toward the array |
| arr_sector | output | 3 | Erase sector toward the array |

## Verification
The bench builds the block with PROG_LAT=5 and ERASE_UNIT_LAT=3. With these values a program holds busy for 5 cycles, and erases hold it for 3, 12 or 24 cycles depending on the sector size. Every busy window is therefore short enough to count exactly, cycle by cycle, for each of the three sector sizes. The 5-cycle program window also leaves room to land a second request inside it. That makes the sequence error, and the case where an error is raised and cleared in the same cycle, easy to reach.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int NSECT      = 8;
    localparam int ADDR_W     = 19;
    localparam int OFF_W      = 20;
    localparam int ERR_W      = 5;
    localparam int UNIT_BYTES = 16384;
    localparam int MAX_UNITS  = 8;

    localparam int E_OPFAIL = 0;
    localparam int E_SIZE   = 1;
    localparam int E_PROT   = 2;
    localparam int E_SEQ    = 3;
    localparam int E_PARAM  = 4;

    typedef enum logic [1:0] {
        PS_BYTE  = 2'b00,
        PS_HALF  = 2'b01,
        PS_WORD  = 2'b10,
        PS_DWORD = 2'b11
    } psize_e;

    typedef struct packed {
        logic       pg;
        psize_e     psize;
        logic       ser;
        logic [3:0] snb;
    } ctrl_t;

    // size of sector i in 16 KiB units
    function automatic int sect_units(input int i);
        if (i < 4)       return 1;
        else if (i == 4) return 4;
        else             return MAX_UNITS;
    endfunction

    function automatic logic [OFF_W-1:0] sect_base(input int i);
        if (i < 4)       return OFF_W'(i * UNIT_BYTES);
        else if (i == 4) return OFF_W'(4 * UNIT_BYTES);
        else             return OFF_W'((i - 4) * MAX_UNITS * UNIT_BYTES);
    endfunction

    function automatic logic [OFF_W:0] sect_end(input int i);
        return {1'b0, sect_base(i)} + (OFF_W+1)'(sect_units(i) * UNIT_BYTES);
    endfunction

    function automatic logic [2:0] sect_of(input logic [ADDR_W-1:0] a);
        if (a[18:16] == 3'b000)      return {1'b0, a[15:14]};
        else if (a[18:17] == 2'b00)  return 3'd4;
        else                         return 3'd4 + {1'b0, a[18:17]};
    endfunction

endpackage

// File: rtl/flash_seq_range.sv
module flash_seq_range
    import flash_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] size,
    output logic             bad_now,
    output logic             done,
    output logic             ok,
    output logic [2:0]       first,
    output logic [2:0]       last
);
    logic           hit_s, hit_e;
    logic [2:0]     s_idx, e_idx;
    logic [OFF_W:0] end_sum;

    always_comb begin
        hit_s   = 1'b0;
        hit_e   = 1'b0;
        s_idx   = '0;
        e_idx   = '0;
        end_sum = {1'b0, off} + {1'b0, size};
        for (int i = 0; i < NSECT; i++) begin
            if (off == sect_base(i)) begin
                hit_s = 1'b1;
                s_idx = 3'(i);
            end
        end
        for (int j = 0; j < NSECT; j++) begin
            if (hit_s && (j >= int'(s_idx)) && (end_sum == sect_end(j))) begin
                hit_e = 1'b1;
                e_idx = 3'(j);
            end
        end
    end

    assign bad_now = req & ~hit_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            ok    <= 1'b0;
            first <= '0;
            last  <= '0;
        end else begin
            done <= req;
            if (req) begin
                ok    <= hit_e;
                first <= hit_e ? s_idx : 3'd0;
                last  <= hit_e ? e_idx : 3'd0;
            end
        end
    end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int PROG_LAT       = 8,
    parameter int ERASE_UNIT_LAT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              ctrl_pg,
    input  logic [1:0]        ctrl_psize,
    input  logic              ctrl_ser,
    input  logic [3:0]        ctrl_snb,
    input  logic              ctrl_start,
    input  logic              word_we,
    input  logic [18:0]       word_addr,
    input  logic [31:0]       word_data,
    input  logic [7:0]        wp_mask,
    input  logic              rng_req,
    input  logic [19:0]       rng_off,
    input  logic [19:0]       rng_size,
    input  logic              clr_we,
    input  logic [4:0]        clr_mask,
    output logic              busy,
    output logic [4:0]        err,
    output logic              rng_done,
    output logic              rng_ok,
    output logic [2:0]        rng_first,
    output logic [2:0]        rng_last,
    output logic              arr_prog_stb,
    output logic              arr_erase_stb,
    output logic [18:0]       arr_addr,
    output logic [31:0]       arr_data,
    output logic [2:0]        arr_sector
);
    localparam int ERASE_MAX = ERASE_UNIT_LAT * MAX_UNITS;
    localparam int MAX_LAT   = (PROG_LAT > ERASE_MAX) ? PROG_LAT : ERASE_MAX;
    localparam int CW        = $clog2(MAX_LAT + 1);

    ctrl_t            cr;
    logic [ERR_W-1:0] err_q, err_set, err_keep;
    logic             rng_bad;
    logic             e_req, e_snb_bad, e_prot, e_go;
    logic             w_req, w_busy, w_size_ok, w_prot, w_go;
    logic [2:0]       e_sec, w_sec;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;

    flash_seq_range u_range (
        .clk     (clk),
        .rst     (rst),
        .req     (rng_req),
        .off     (rng_off),
        .size    (rng_size),
        .bad_now (rng_bad),
        .done    (rng_done),
        .ok      (rng_ok),
        .first   (rng_first),
        .last    (rng_last)
    );

    flash_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .busy     (busy)
    );

    // control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            cr <= '{pg: 1'b0, psize: PS_BYTE, ser: 1'b0, snb: 4'd0};
        end else if (ctrl_we) begin
            cr <= '{pg: ctrl_pg, psize: psize_e'(ctrl_psize), ser: ctrl_ser, snb: ctrl_snb};
        end
    end

    // request decode; erase is judged first so a program in the same cycle sees it as busy
    always_comb begin
        e_sec     = cr.snb[2:0];
        e_req     = ctrl_start & cr.ser;
        e_snb_bad = cr.snb[3];
        e_prot    = wp_mask[e_sec];
        e_go      = e_req & ~busy & ~e_snb_bad & ~e_prot;

        w_sec     = sect_of(word_addr);
        w_req     = word_we & cr.pg;
        w_busy    = busy | e_go;
        w_size_ok = (cr.psize == PS_WORD);
        w_prot    = wp_mask[w_sec];
        w_go      = w_req & ~w_busy & w_size_ok & ~w_prot;

        err_set           = '0;
        err_set[E_OPFAIL] = e_req & ~busy & e_snb_bad;
        err_set[E_SIZE]   = w_req & ~w_busy & ~w_size_ok;
        err_set[E_PROT]   = (e_req & ~busy & ~e_snb_bad & e_prot)
                          | (w_req & ~w_busy & w_size_ok & w_prot);
        err_set[E_SEQ]    = (e_req & busy) | (w_req & w_busy);
        err_set[E_PARAM]  = rng_bad;

        err_keep = err_q & ~(clr_we ? clr_mask : '0);

        tmr_load = e_go | w_go;
        tmr_val  = e_go ? CW'(ERASE_UNIT_LAT * sect_units(int'(e_sec))) : CW'(PROG_LAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q         <= '0;
            arr_prog_stb  <= 1'b0;
            arr_erase_stb <= 1'b0;
            arr_addr      <= '0;
            arr_data      <= '0;
            arr_sector    <= '0;
        end else begin
            err_q         <= err_keep | err_set;
            arr_prog_stb  <= w_go;
            arr_erase_stb <= e_go;
            if (w_go) begin
                arr_addr <= word_addr;
                arr_data <= word_data;
            end
            if (e_go) arr_sector <= e_sec;
        end
    end

    assign err = err_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic [4:0] err,
    input logic       clr_we,
    input logic [4:0] clr_mask,
    input logic [7:0] wp_mask,
    input logic       arr_prog_stb,
    input logic       arr_erase_stb,
    input logic [2:0] arr_sector
);
    logic [7:0] wp_q;
    logic [4:0] err_q;
    logic [4:0] clr_q;

    always_ff @(posedge clk) begin
        wp_q  <= wp_mask;
        err_q <= err;
        clr_q <= clr_we ? clr_mask : 5'd0;
    end

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(arr_prog_stb && arr_erase_stb)); // R7

    AST_STB_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (arr_prog_stb || arr_erase_stb) |-> !$past(busy)); // R7

    AST_PROG_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_prog_stb |-> busy); // R5

    AST_ERASE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_erase_stb |-> busy); // R4

    AST_ERASE_NOT_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        arr_erase_stb |-> !wp_q[arr_sector]); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q & ~err & ~clr_q) == 5'd0); // R10
endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .err           (err),
    .clr_we        (clr_we),
    .clr_mask      (clr_mask),
    .wp_mask       (wp_mask),
    .arr_prog_stb  (arr_prog_stb),
    .arr_erase_stb (arr_erase_stb),
    .arr_sector    (arr_sector)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
    localparam int PL  = 5;
    localparam int EUL = 3;
    localparam int K   = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 0, ctrl_pg = 0, ctrl_ser = 0, ctrl_start = 0;
    logic [1:0]  ctrl_psize = 0;
    logic [3:0]  ctrl_snb = 0;
    logic        word_we = 0;
    logic [18:0] word_addr = 0;
    logic [31:0] word_data = 0;
    logic [7:0]  wp_mask = 0;
    logic        rng_req = 0;
    logic [19:0] rng_off = 0, rng_size = 0;
    logic        clr_we = 0;
    logic [4:0]  clr_mask = 0;
    logic        busy, rng_done, rng_ok, arr_prog_stb, arr_erase_stb;
    logic [4:0]  err;
    logic [2:0]  rng_first, rng_last, arr_sector;
    logic [18:0] arr_addr;
    logic [31:0] arr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    flash_seq #(.PROG_LAT(PL), .ERASE_UNIT_LAT(EUL)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_pg(ctrl_pg), .ctrl_psize(ctrl_psize),
        .ctrl_ser(ctrl_ser), .ctrl_snb(ctrl_snb), .ctrl_start(ctrl_start), .word_we(word_we),
        .word_addr(word_addr), .word_data(word_data), .wp_mask(wp_mask), .rng_req(rng_req),
        .rng_off(rng_off), .rng_size(rng_size), .clr_we(clr_we), .clr_mask(clr_mask),
        .busy(busy), .err(err), .rng_done(rng_done), .rng_ok(rng_ok), .rng_first(rng_first),
        .rng_last(rng_last), .arr_prog_stb(arr_prog_stb), .arr_erase_stb(arr_erase_stb),
        .arr_addr(arr_addr), .arr_data(arr_data), .arr_sector(arr_sector)
    );

    // bench model of the sector map
    function automatic int m_base(input int i);
        int t [8] = '{0, 16, 32, 48, 64, 128, 256, 384};
        return t[i] * K;
    endfunction
    function automatic int m_size(input int i);
        return (i < 4) ? 16 * K : ((i == 4) ? 64 * K : 128 * K);
    endfunction
    function automatic int m_sect(input int a);
        int s = 0;
        for (int i = 0; i < 8; i++) if (a >= m_base(i)) s = i;
        return s;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_ctrl(input bit pg, input bit [1:0] ps, input bit ser, input bit [3:0] snb);
        @(negedge clk);
        ctrl_we = 1; ctrl_pg = pg; ctrl_psize = ps; ctrl_ser = ser; ctrl_snb = snb;
        @(negedge clk);
        ctrl_we = 0;
    endtask
    task automatic put_start();
        @(negedge clk); ctrl_start = 1;
        @(negedge clk); ctrl_start = 0;
    endtask
    task automatic put_word(input int a, input logic [31:0] d);
        @(negedge clk); word_we = 1; word_addr = 19'(a); word_data = d;
        @(negedge clk); word_we = 0;
    endtask
    task automatic put_range(input int off, input int size);
        @(negedge clk); rng_req = 1; rng_off = 20'(off); rng_size = 20'(size);
        @(negedge clk); rng_req = 0;
    endtask
    task automatic put_clr(input logic [4:0] m);
        @(negedge clk); clr_we = 1; clr_mask = m;
        @(negedge clk); clr_we = 0;
    endtask
    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic range_case(input int off, input int size);
        int fi = -1, la = -1;
        for (int i = 0; i < 8; i++) if (off == m_base(i)) fi = i;
        if (fi >= 0)
            for (int j = fi; j < 8; j++) if (off + size == m_base(j) + m_size(j)) la = j;
        put_range(off, size);
        chk("R2 done", rng_done, 1);
        chk("R2 ok", rng_ok, la >= 0);
        if (la >= 0) begin
            chk("R2 first", rng_first, fi);
            chk("R2 last", rng_last, la);
        end else begin
            chk("R3 param err", err[4], 1);
            put_clr(5'b10000);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 strobes", {arr_prog_stb, arr_erase_stb}, 0);

        // R2 / R3 directed
        range_case(0, 16 * K);
        range_case(16 * K, 48 * K);
        range_case(64 * K, 64 * K);
        range_case(0, 512 * K);
        range_case(128 * K, 256 * K);
        range_case(384 * K, 128 * K);
        range_case(8 * K, 8 * K);
        range_case(0, 20 * K);
        range_case(128 * K, 0);
        range_case(64 * K, 16 * K);
        // R2 random
        for (int it = 0; it < 200; it++) begin
            int a = $urandom_range(0, 7);
            int b = $urandom_range(0, 7);
            int off = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 511) * K : m_base(a);
            int en = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 512) * K : m_base(b) + m_size(b);
            int sz = (en > off) ? en - off : $urandom_range(0, 64) * K;
            range_case(off, sz);
        end

        // R5 program
        put_ctrl(1, 2'b10, 0, 0);
        put_word(32'h104, 32'hA5C3_0F11);
        chk("R5 prog stb", arr_prog_stb, 1);
        chk("R5 addr", arr_addr, 32'h104);
        chk("R5 data", arr_data, 32'hA5C3_0F11);
        busy_len(n);
        chk("R5 busy len", n, PL);
        chk("R5 strobe single", arr_prog_stb, 0);

        // R7 word during busy
        put_word(32'h200, 32'h1);
        put_word(32'h204, 32'h2);
        chk("R7 no stb", arr_prog_stb, 0);
        chk("R7 seq err", err[3], 1);
        chk("R7 addr kept", arr_addr, 32'h200);
        busy_len(n);
        chk("R7 busy not extended", n, PL - 2);
        put_clr(5'b01000);
        chk("R10 cleared", err, 0);

        // R10 set wins over clear in same cycle
        put_word(32'h300, 32'h3);
        put_word(32'h304, 32'h4);
        @(negedge clk); word_we = 1; word_addr = 19'h308; clr_we = 1; clr_mask = 5'b01000;
        @(negedge clk); word_we = 0; clr_we = 0;
        chk("R10 set wins", err[3], 1);
        busy_len(n);
        put_clr(5'b11111);

        // R6 bad width and program disabled
        put_ctrl(1, 2'b01, 0, 0);
        put_word(32'h400, 32'h5);
        chk("R6 size err", err[1], 1);
        chk("R6 no stb", arr_prog_stb, 0);
        chk("R6 no busy", busy, 0);
        put_clr(5'b00010);
        put_ctrl(0, 2'b10, 0, 0);
        put_word(32'h404, 32'h6);
        chk("R6 pg off err", err, 0);
        chk("R6 pg off stb", arr_prog_stb, 0);
        chk("R6 pg off busy", busy, 0);

        // R8 protection
        wp_mask = 8'b0000_0100;
        put_ctrl(1, 2'b10, 0, 0);
        put_word(32 * K + 4, 32'h7);
        chk("R8 prog prot err", err[2], 1);
        chk("R8 prog no stb", arr_prog_stb, 0);
        put_clr(5'b00100);
        put_ctrl(0, 2'b10, 1, 4'd2);
        put_start();
        chk("R8 erase prot err", err[2], 1);
        chk("R8 erase no stb", arr_erase_stb, 0);
        chk("R8 erase no busy", busy, 0);
        put_clr(5'b00100);
        wp_mask = 0;

        // R4 erase of each sector size
        for (int s = 0; s < 8; s++) begin
            put_ctrl(0, 2'b10, 1, 4'(s));
            put_start();
            chk("R4 erase stb", arr_erase_stb, 1);
            chk("R4 sector", arr_sector, s);
            busy_len(n);
            chk("R4 busy len", n, EUL * m_size(s) / (16 * K));
        end
        // R4 start with erase field clear does nothing
        put_ctrl(0, 2'b10, 0, 4'd1);
        put_start();
        chk("R4 no ser stb", arr_erase_stb, 0);
        chk("R4 no ser busy", busy, 0);

        // R7 start during erase
        put_ctrl(0, 2'b10, 1, 4'd6);
        put_start();
        put_start();
        chk("R7 erase seq err", err[3], 1);
        chk("R7 erase no second stb", arr_erase_stb, 0);
        busy_len(n);
        chk("R7 erase len", n, 24 - 2);
        put_clr(5'b01000);

        // R9 sector out of range
        put_ctrl(0, 2'b10, 1, 4'd9);
        put_start();
        chk("R9 op fail", err[0], 1);
        chk("R9 no stb", arr_erase_stb, 0);
        chk("R9 no busy", busy, 0);
        put_clr(5'b00001);
        chk("R10 all clear", err, 0);

        // R5 / R8 random programs
        put_ctrl(1, 2'b10, 0, 0);
        for (int it = 0; it < 100; it++) begin
            int a = $urandom_range(0, 131071) * 4;
            logic [31:0] d = $urandom;
            bit pr;
            wp_mask = 8'($urandom);
            pr = wp_mask[m_sect(a)];
            put_word(a, d);
            chk("R8 rand stb", arr_prog_stb, !pr);
            chk("R8 rand prot", err[2], pr);
            if (!pr) begin
                chk("R5 rand addr", arr_addr, a);
                chk("R5 rand data", arr_data, d);
            end
            busy_len(n);
            put_clr(5'b11111);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule